// File: doc/BRIEF.md
# Asynchronous Host Register Port

This block lets an external processor reach a bank of 16-bit registers over an asynchronous parallel bus. It accepts an 11-bit byte address that can be multiplexed with the data and held by an address latch. It also takes an active-low chip select and one of two strobe conventions. The first convention uses separate read and write strobes. The second uses a single data strobe with a direction line. Every bus control, address and data pin is brought into the system clock through a synchronizer chain. Each access becomes a single-cycle write request, or a combinational read, on a simple register-bank port.

The data path handles both an 8-bit and a 16-bit bus. On a narrow bus the address LSB picks the byte lane. On a wide bus the same pin acts as a static byte-swap control. Pad drivers stay outside the block. For each three-state signal the block gives a value and an output enable: the two data byte lanes, the ready handshake and the active-low interrupt. The interrupt is built from a set of event inputs. It is qualified by an enable register and a drive-high control bit. Both of these are local to the block and sit at two fixed word addresses.

Top module: `hostbus_regif`

## Requirements
- R1: With `width_i`=0, a read drives `d_o[7:0]` with register bits 7:0 when address bit 0 is 0, and with bits 15:8 when it is 1. `d_oe_hi_o` stays 0 and `d_o[15:8]` reads 0.
- R2: With `width_i`=1, a read drives all 16 bits and raises both enables. Address bit 0 = 0 maps the register straight, and 1 exchanges the two bytes.
- R3: With `width_i`=0, a write sets only the byte lane chosen by address bit 0 (`reg_be_o` 01 for bit 0 = 0, 10 for bit 0 = 1), loading it from `d_i[7:0]`.
- R4: With `width_i`=1, a write has `reg_be_o`=11. Address bit 0 = 1 stores `d_i[7:0]` into bits 15:8 and `d_i[15:8]` into bits 7:0.
- R5: The address used is taken from `addr_i` while `ale_i` is high. While `ale_i` is low, the value seen last while it was high is held. Address bits 10:1 form the word address.
- R6: With `mode_i`=0, `strb_a_n_i` low is a read and `strb_b_i` low is a write. With `mode_i`=1, `strb_a_n_i` low qualifies an access whose direction is `strb_b_i` (1 read, 0 write). No access takes place while it is high.
- R7: The data enables are raised only during a selected read. `rdy_oe_o` is high only while `cs_n_i` (after synchronization) is low. All enables are 0 in reset.
- R8: Each write strobe produces exactly one single-cycle write request, in the first cycle the synchronized write is active.
- R9: `rdy_o` is 0 while an access is in progress. It becomes 1 two clocks after the synchronized strobe goes active, and returns to 0 when the strobe is released.
- R10: `irq_n_o` is 0 with `irq_oe_o`=1 whenever some `irq_src_i` bit is set together with its enable bit. After reset all enables are 0 and `irq_oe_o` is 0.
- R11: When no enabled source is active, `irq_oe_o` equals bit 0 of the control register, with `irq_n_o`=1.
- R12: The enable register sits at word 0x3FE and the control register at word 0x3FF. Both can be read and written through the bus, and accesses to them issue no request on the register-bank port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Strobe convention: 0 separate strobes, 1 data strobe with direction |
| width_i | input | 1 | Bus width: 1 sixteen bits, 0 eight bits |
| cs_n_i | input | 1 | Chip select, active low |
| strb_a_n_i | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| strb_b_i | input | 1 | Write strobe active low (mode 0) or direction, 1 read (mode 1) |
| ale_i | input | 1 | Address latch enable, transparent while high |
| addr_i | input | AW | Byte address; bit 0 is lane select or swap |
| d_i | input | 16 | Data bus input from the pads |
| d_o | output | 16 | Data bus value for the pads |
| d_oe_lo_o | output | 1 | Output enable for data bits 7:0 |
| d_oe_hi_o | output | 1 | Output enable for data bits 15:8 |
| rdy_o | output | 1 | Ready value: 1 complete, 0 in progress |
| rdy_oe_o | output | 1 | Output enable for the ready pad |
| irq_src_i | input | NSRC | Event sources, active high, in the system clock |
| irq_n_o | output | 1 | Interrupt value, active low |
| irq_oe_o | output | 1 | Output enable for the interrupt pad |
| reg_addr_o | output | AW-1 | Word address to the register bank |
| reg_wr_o | output | 1 | Single-cycle write request |
| reg_be_o | output | 2 | Byte enables of the write |
| reg_wdata_o | output | 16 | Write data, already lane-mapped |
| reg_rdata_i | input | 16 | Read data from the register bank at `reg_addr_o` |

## Verification
The bench uses the default parameters: an 11-bit address, eight interrupt sources, two synchronizer stages and a ready latency of two. With these values the ready transition falls at a fixed fourth clock after a strobe is driven, so the bench can sample one cycle before it and at it. Both local interrupt registers sit at the top of the 10-bit word space, where the bench can reach them with ordinary accesses. The bench models the register bank itself. This lets it count write requests per strobe and inspect the bytes each write lands in.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    localparam int DW = 16;

    typedef struct packed {
        logic [1:0]    be;
        logic [DW-1:0] data;
    } wr_lane_t;

    // Map a register word onto the data pins.
    function automatic logic [DW-1:0] rd_lanes(input logic wide, input logic sel,
                                               input logic [DW-1:0] r);
        if (!wide) return {8'h00, (sel ? r[15:8] : r[7:0])};
        return sel ? {r[7:0], r[15:8]} : r;
    endfunction

    // Map the data pins onto a register write with byte enables.
    function automatic wr_lane_t wr_lanes(input logic wide, input logic sel,
                                          input logic [DW-1:0] bus);
        wr_lane_t w;
        if (!wide) begin
            w.be   = sel ? 2'b10 : 2'b01;
            w.data = {bus[7:0], bus[7:0]};
        end else begin
            w.be   = 2'b11;
            w.data = sel ? {bus[7:0], bus[15:8]} : bus;
        end
        return w;
    endfunction

endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/hbr_irq.sv
module hbr_irq #(
    parameter int            NSRC      = 8,
    parameter int            WAW       = 10,
    parameter logic [WAW-1:0] IEN_ADDR  = '1 - 1'b1,
    parameter logic [WAW-1:0] ICTL_ADDR = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WAW-1:0]  addr_i,
    input  logic            wr_i,
    input  logic [1:0]      be_i,
    input  logic [15:0]     wdata_i,
    input  logic [NSRC-1:0] src_i,
    output logic            hit_o,
    output logic [15:0]     rdata_o,
    output logic            irq_n_o,
    output logic            irq_oe_o
);
    localparam logic [15:0] SRC_MASK = 16'((32'd1 << NSRC) - 32'd1);

    typedef struct packed {
        logic [15:0] ien;
        logic        drv_hi;
    } irq_st_t;

    irq_st_t     st_d, st_q;
    logic [15:0] lane_mask;
    logic [15:0] src_ext;
    logic        any_act;

    always_comb begin
        st_d      = st_q;
        lane_mask = {{8{be_i[1]}}, {8{be_i[0]}}};
        src_ext   = 16'(src_i);
        hit_o     = (addr_i == IEN_ADDR) || (addr_i == ICTL_ADDR);
        if (wr_i && addr_i == IEN_ADDR)
            st_d.ien = ((st_q.ien & ~lane_mask) | (wdata_i & lane_mask)) & SRC_MASK;
        if (wr_i && addr_i == ICTL_ADDR && be_i[0])
            st_d.drv_hi = wdata_i[0];
        rdata_o  = (addr_i == IEN_ADDR) ? st_q.ien : {15'd0, st_q.drv_hi};
        any_act  = |(src_ext & st_q.ien);
        irq_n_o  = !any_act;
        irq_oe_o = any_act || st_q.drv_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: a low interrupt needs an enabled, active source
    a_r10_low_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oe_o && !irq_n_o) |-> ((src_ext & st_q.ien) != 16'd0));
    // R11: driving high with nothing pending needs the control bit
    a_r11_high_needs_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oe_o && irq_n_o) |-> st_q.drv_hi);
endmodule

// File: rtl/hostbus_regif.sv
module hostbus_regif
    import hbr_pkg::*;
#(
    parameter int               AW          = 11,
    parameter int               NSRC        = 8,
    parameter int               SYNC_STAGES = 2,
    parameter int               RDY_LAT     = 2,
    parameter logic [AW-2:0]    IEN_ADDR    = 10'h3FE,
    parameter logic [AW-2:0]    ICTL_ADDR   = 10'h3FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_i,
    input  logic            width_i,
    input  logic            cs_n_i,
    input  logic            strb_a_n_i,
    input  logic            strb_b_i,
    input  logic            ale_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [15:0]     d_i,
    output logic [15:0]     d_o,
    output logic            d_oe_lo_o,
    output logic            d_oe_hi_o,
    output logic            rdy_o,
    output logic            rdy_oe_o,
    input  logic [NSRC-1:0] irq_src_i,
    output logic            irq_n_o,
    output logic            irq_oe_o,
    output logic [AW-2:0]   reg_addr_o,
    output logic            reg_wr_o,
    output logic [1:0]      reg_be_o,
    output logic [15:0]     reg_wdata_o,
    input  logic [15:0]     reg_rdata_i
);
    localparam int WAW  = AW - 1;
    localparam int CNTW = $clog2(RDY_LAT + 1);
    localparam int BW   = AW + DW;

    typedef struct packed {
        logic [AW-1:0]   al;
        logic            wr_prev;
        logic [CNTW-1:0] cnt;
    } bus_st_t;

    bus_st_t     st_d, st_q;
    logic [3:0]  ctl_s;
    logic [BW-1:0] bus_s;
    logic        cs_n_s, sa_n_s, sb_s, ale_s;
    logic [AW-1:0] addr_s, eff_addr;
    logic [15:0] data_s;
    logic        sel, rd_act, wr_act, acc_act, wr_pulse;
    logic        loc_hit;
    logic [15:0] loc_rdata, rdata;
    wr_lane_t    wl;

    hbr_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .async_i({cs_n_i, strb_a_n_i, strb_b_i, ale_i}),
        .sync_o (ctl_s)
    );

    hbr_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
        .clk(clk), .rst_n(rst_n),
        .async_i({addr_i, d_i}),
        .sync_o (bus_s)
    );

    assign {cs_n_s, sa_n_s, sb_s, ale_s} = ctl_s;
    assign {addr_s, data_s}              = bus_s;

    always_comb begin
        st_d = st_q;
        sel  = !cs_n_s;
        if (mode_i) begin
            rd_act = sel && !sa_n_s && sb_s;
            wr_act = sel && !sa_n_s && !sb_s;
        end else begin
            rd_act = sel && !sa_n_s;
            wr_act = sel && !sb_s && sa_n_s;
        end
        acc_act = rd_act || wr_act;

        // address latch: follow the pins while enabled, hold otherwise
        eff_addr = ale_s ? addr_s : st_q.al;
        st_d.al  = eff_addr;

        wr_pulse     = wr_act && !st_q.wr_prev;
        st_d.wr_prev = wr_act;

        if (!acc_act)                        st_d.cnt = '0;
        else if (st_q.cnt != CNTW'(RDY_LAT)) st_d.cnt = st_q.cnt + 1'b1;

        wl          = wr_lanes(width_i, eff_addr[0], data_s);
        reg_addr_o  = eff_addr[AW-1:1];
        reg_be_o    = wl.be;
        reg_wdata_o = wl.data;
        reg_wr_o    = wr_pulse && !loc_hit;

        rdata     = loc_hit ? loc_rdata : reg_rdata_i;
        d_o       = rd_act ? rd_lanes(width_i, eff_addr[0], rdata) : 16'd0;
        d_oe_lo_o = rd_act;
        d_oe_hi_o = rd_act && width_i;

        rdy_o    = acc_act && (st_q.cnt == CNTW'(RDY_LAT));
        rdy_oe_o = sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    hbr_irq #(.NSRC(NSRC), .WAW(WAW), .IEN_ADDR(IEN_ADDR), .ICTL_ADDR(ICTL_ADDR)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr_o),
        .wr_i    (wr_pulse && loc_hit),
        .be_i    (wl.be),
        .wdata_i (wl.data),
        .src_i   (irq_src_i),
        .hit_o   (loc_hit),
        .rdata_o (loc_rdata),
        .irq_n_o (irq_n_o),
        .irq_oe_o(irq_oe_o)
    );

    // R8: a write request never lasts two cycles
    a_r8_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);
    // R9: completion only after the access was already active a cycle earlier
    a_r9_ready_after_active: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> $past(acc_act));
    // R1: the upper lane stays undriven on the narrow bus
    a_r1_narrow_upper_off: assert property (@(posedge clk) disable iff (!rst_n)
        !width_i |-> !d_oe_hi_o);
    // R12: local registers never reach the bank port
    a_r12_local_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> (reg_addr_o != IEN_ADDR && reg_addr_o != ICTL_ADDR));
    // R7: ready enable tracks chip select
    a_r7_ready_oe_select: assert property (@(posedge clk) disable iff (!rst_n)
        d_oe_lo_o |-> rdy_oe_o);
endmodule

// File: tb/hostbus_regif_bench.sv
`timescale 1ns/1ps
module hostbus_regif_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0, width = 1'b1, cs_n = 1'b1, sa_n = 1'b1, sb = 1'b1, ale = 1'b1;
    logic [10:0] addr = '0;
    logic [15:0] d_in = '0;
    logic [15:0] d_o;
    logic        oe_lo, oe_hi, rdy, rdy_oe, irq_n, irq_oe;
    logic [7:0]  src = '0;
    logic [9:0]  reg_addr;
    logic        reg_wr;
    logic [1:0]  reg_be;
    logic [15:0] reg_wdata, reg_rdata;

    int total = 0;
    int bad   = 0;

    // bench-owned register bank with a preload port
    logic [15:0] bank [1024];
    int          bank_wr_cnt = 0;
    logic        pl_en = 1'b0;
    logic [9:0]  pl_addr = '0;
    logic [15:0] pl_data = '0;

    always #2 clk = ~clk;

    hostbus_regif u_hostbus_regif (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .width_i(width),
        .cs_n_i(cs_n), .strb_a_n_i(sa_n), .strb_b_i(sb), .ale_i(ale),
        .addr_i(addr), .d_i(d_in), .d_o(d_o), .d_oe_lo_o(oe_lo), .d_oe_hi_o(oe_hi),
        .rdy_o(rdy), .rdy_oe_o(rdy_oe), .irq_src_i(src), .irq_n_o(irq_n),
        .irq_oe_o(irq_oe), .reg_addr_o(reg_addr), .reg_wr_o(reg_wr),
        .reg_be_o(reg_be), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
    );

    assign reg_rdata = bank[reg_addr];

    always @(posedge clk) begin
        if (pl_en) bank[pl_addr] <= pl_data;
        else if (reg_wr) begin
            if (reg_be[0]) bank[reg_addr][7:0]  <= reg_wdata[7:0];
            if (reg_be[1]) bank[reg_addr][15:8] <= reg_wdata[15:8];
            bank_wr_cnt <= bank_wr_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [9:0] a, input logic [15:0] v);
        @(negedge clk); pl_en = 1'b1; pl_addr = a; pl_data = v;
        @(negedge clk); pl_en = 1'b0;
    endtask

    // one bus access; samples one clock before and at the expected ready point
    task automatic access(input logic m, input logic wide, input logic rd,
                          input logic [10:0] a, input logic [15:0] d,
                          output logic [15:0] q, output logic olo, output logic ohi,
                          output logic r3, output logic r4, output logic roe,
                          output int nwr);
        int n0;
        @(negedge clk);
        mode = m; width = wide; addr = a; d_in = d;
        n0 = bank_wr_cnt;
        cs_n = 1'b0; sb = rd; sa_n = m ? 1'b0 : !rd;
        repeat (3) @(posedge clk);
        @(negedge clk); r3 = rdy;
        @(posedge clk);
        @(negedge clk); r4 = rdy; q = d_o; olo = oe_lo; ohi = oe_hi; roe = rdy_oe;
        cs_n = 1'b1; sa_n = 1'b1; sb = 1'b1;
        repeat (4) @(negedge clk);
        nwr = bank_wr_cnt - n0;
    endtask

    typedef struct packed {
        logic        m;
        logic        wide;
        logic        lsb;
        logic [9:0]  w;
        logic [15:0] exp;
        logic        ohi;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 10'h010, 16'h00C3, 1'b0},
        '{1'b0, 1'b0, 1'b1, 10'h010, 16'h00A5, 1'b0},
        '{1'b1, 1'b1, 1'b0, 10'h020, 16'h1234, 1'b1},
        '{1'b1, 1'b1, 1'b1, 10'h020, 16'h3412, 1'b1},
        '{1'b1, 1'b0, 1'b1, 10'h031, 16'h00BE, 1'b0},
        '{1'b0, 1'b1, 1'b1, 10'h031, 16'hEFBE, 1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] q;
        logic olo, ohi, r3, r4, roe;
        int nwr;

        repeat (3) @(negedge clk);
        // reset state (R7, R10)
        check("R7 reset data oe", {30'd0, oe_hi, oe_lo}, 0);
        check("R7 reset ready oe", rdy_oe, 0);
        check("R10 reset irq oe", irq_oe, 0);
        rst_n = 1'b1;

        preload(10'h010, 16'hA5C3);
        preload(10'h020, 16'h1234);
        preload(10'h031, 16'hBEEF);

        // read vectors (R1, R2, R6)
        for (int i = 0; i < NV; i++) begin
            access(VEC[i].m, VEC[i].wide, 1'b1, {VEC[i].w, VEC[i].lsb}, 16'h0,
                   q, olo, ohi, r3, r4, roe, nwr);
            check(VEC[i].wide ? "R2 read data" : "R1 read data", q, VEC[i].exp);
            check("R1 R2 upper oe", ohi, VEC[i].ohi);
            check("R6 read decode", {olo, 5'd0, nwr[7:0]}, {1'b1, 5'd0, 8'd0});
        end

        // ready timing and ready enable (R9, R7)
        access(1'b0, 1'b1, 1'b1, {10'h020, 1'b0}, 16'h0, q, olo, ohi, r3, r4, roe, nwr);
        check("R9 ready in progress", r3, 0);
        check("R9 ready complete", r4, 1);
        check("R7 ready oe selected", roe, 1);
        check("R9 ready released", rdy, 0);

        // narrow writes (R3, R8)
        preload(10'h040, 16'h0000);
        access(1'b0, 1'b0, 1'b0, {10'h040, 1'b1}, 16'h007E, q, olo, ohi, r3, r4, roe, nwr);
        check("R8 one request", nwr, 1);
        check("R3 upper byte write", bank[10'h040], 16'h7E00);
        check("R6 write has no data oe", olo, 0);
        access(1'b0, 1'b0, 1'b0, {10'h040, 1'b0}, 16'h0011, q, olo, ohi, r3, r4, roe, nwr);
        check("R3 lower byte write", bank[10'h040], 16'h7E11);
        check("R9 write ready", r4, 1);

        // wide swapped write in data-strobe mode (R4, R6)
        access(1'b1, 1'b1, 1'b0, {10'h041, 1'b1}, 16'hABCD, q, olo, ohi, r3, r4, roe, nwr);
        check("R4 swapped write", bank[10'h041], 16'hCDAB);
        check("R8 one request mode1", nwr, 1);
        access(1'b1, 1'b1, 1'b0, {10'h042, 1'b0}, 16'hABCD, q, olo, ohi, r3, r4, roe, nwr);
        check("R4 straight write", bank[10'h042], 16'hABCD);

        // data strobe high in mode 1: no access (R6)
        begin
            int n0;
            @(negedge clk);
            n0 = bank_wr_cnt; mode = 1'b1; addr = {10'h042, 1'b0}; d_in = 16'h5555;
            cs_n = 1'b0; sa_n = 1'b1; sb = 1'b0;
            repeat (6) @(negedge clk);
            check("R6 no access without data strobe", {bank_wr_cnt - n0, 31'(rdy)}, 0);
            check("R6 bank unchanged", bank[10'h042], 16'hABCD);
            cs_n = 1'b1; sb = 1'b1;
            repeat (4) @(negedge clk);
        end

        // read strobe without chip select (R7)
        @(negedge clk);
        mode = 1'b0; width = 1'b1; sa_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R7 no oe unselected", {29'd0, rdy_oe, oe_hi, oe_lo}, 0);
        sa_n = 1'b1;
        repeat (3) @(negedge clk);

        // address latch (R5)
        preload(10'h050, 16'h1111);
        preload(10'h051, 16'h2222);
        @(negedge clk); addr = {10'h050, 1'b0}; ale = 1'b1;
        repeat (4) @(negedge clk); ale = 1'b0;
        repeat (4) @(negedge clk);
        access(1'b0, 1'b1, 1'b1, {10'h051, 1'b0}, 16'h0, q, olo, ohi, r3, r4, roe, nwr);
        check("R5 latched address held", q, 16'h1111);
        @(negedge clk); ale = 1'b1;
        access(1'b0, 1'b1, 1'b1, {10'h051, 1'b0}, 16'h0, q, olo, ohi, r3, r4, roe, nwr);
        check("R5 transparent address", q, 16'h2222);

        // interrupt (R10, R11, R12)
        @(negedge clk); src = 8'h01;
        repeat (2) @(negedge clk);
        check("R10 disabled source", {irq_oe, irq_n}, 2'b01);
        access(1'b0, 1'b1, 1'b0, {10'h3FE, 1'b0}, 16'h0005, q, olo, ohi, r3, r4, roe, nwr);
        check("R12 enable not forwarded", nwr, 0);
        check("R10 enabled source", {irq_oe, irq_n}, 2'b10);
        access(1'b0, 1'b1, 1'b1, {10'h3FE, 1'b0}, 16'h0, q, olo, ohi, r3, r4, roe, nwr);
        check("R12 enable readback", q, 16'h0005);
        @(negedge clk); src = 8'h02;
        @(negedge clk);
        check("R10 unenabled source idle", {irq_oe, irq_n}, 2'b01);
        access(1'b0, 1'b1, 1'b0, {10'h3FF, 1'b0}, 16'h0001, q, olo, ohi, r3, r4, roe, nwr);
        check("R11 drive high", {irq_oe, irq_n}, 2'b11);
        check("R12 control not forwarded", nwr, 0);
        access(1'b0, 1'b1, 1'b1, {10'h3FF, 1'b0}, 16'h0, q, olo, ohi, r3, r4, roe, nwr);
        check("R12 control readback", q, 16'h0001);
        @(negedge clk); src = 8'h04;
        @(negedge clk);
        check("R10 overrides drive high", {irq_oe, irq_n}, 2'b10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule